// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This unit watches a running calendar (second, minute, hour, day of month, day of week, month, year) supplied by an external time counter and raises an interrupt when the calendar reaches a programmed alarm time. The comparison runs once per seconds tick. Any field can be excluded from the comparison by a per-field ignore mask. Day of week is excluded after reset.

Software reaches the alarm fields, the ignore mask, the enable bits, the status bits and a pending flag through a 16-bit register port with registered read data. Writes to the alarm fields, the mask and the enable bits first land in shadow copies. They only reach the comparator after a commit request and a fixed busy window. A comparison therefore never sees a half-written alarm.

A one-shot mode disarms the alarm by itself when it fires. A separate pending flag records that an alarm has occurred. This flag outlives the status bit until software clears it.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset, `alarm_irq` is 0. Reads return 0x0000 from CTRL (0x00), STAT (0x02), ENA (0x04), PEND (0x2E) and every alarm slot. MASK (0x08) reads 0x0010, so day of week is ignored.
- R2: Alarm slot, MASK and ENA writes go to shadow storage. A write with bit 0 set to COMMIT (0x3C) sets CTRL bit 6 (busy) for COMMIT_CYC cycles. The shadow values then become visible to reads and to the comparator. Until that point, reads return the old values.
- R3: In a cycle with `sec_tick` high and ENA bit 0 set, a match sets STAT bit 0 and drives `alarm_irq` high from the next cycle. A match means every field whose MASK bit is clear equals its alarm slot. Without `sec_tick`, no match is recorded.
- R4: MASK bit i removes field i from the comparison. The fields and their slot addresses 0x18 + 2*i are, by i from 0 to 6: second, minute, hour, day of month, day of week, month, year.
- R5: Each slot stores all 16 written bits and reads them back. Only the low bits take part in the comparison: 6, 6, 5, 5, 3, 4 and 7 bits for fields 0 to 6.
- R6: When ENA bit 2 (one-shot) is set, a recorded match also clears ENA bit 0 in the same cycle. Later matching ticks then set nothing.
- R7: With ENA bit 0 clear, a matching tick changes neither STAT, PEND nor `alarm_irq`.
- R8: A recorded match sets PEND bit 4. The flag stays set after STAT is cleared and is cleared only by writing 1 to PEND bit 4.
- R9: With CLR_ON_READ=0 (default), writing 1 to a STAT bit clears it and writing 0 leaves it. With CLR_ON_READ=1, a STAT read clears it. `alarm_irq` falls with STAT bit 0.
- R10: A pulse on `lp_evt` sets STAT bit 3. This bit does not raise `alarm_irq` and clears the same way as bit 0.
- R11: A commit request made while busy is ignored and does not extend the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_re` |
| sec_tick | input | 1 | One-cycle pulse per second, qualifies the comparison |
| lp_evt | input | 1 | Low-power event, sets STAT bit 3 |
| cur_sec | input | 6 | Live second |
| cur_min | input | 6 | Live minute |
| cur_hour | input | 5 | Live hour |
| cur_dom | input | 5 | Live day of month |
| cur_dow | input | 3 | Live day of week |
| cur_mon | input | 4 | Live month |
| cur_year | input | 7 | Live year offset |
| alarm_irq | output | 1 | Registered alarm interrupt, equal to STAT bit 0 |

## Verification
The assertions assume the following about the inputs:
- `sec_tick` is a single-cycle pulse.
- The live calendar fields are steady in the cycle the tick is sampled.
- At most one register access occurs per cycle, so a status clear and a status read never coincide.

The stimulus keeps within these rules:
- It drives every strobe for exactly one cycle, on the falling clock edge.
- It changes the live fields only while `sec_tick` is low.
- It waits out the full busy window after every commit before it depends on new alarm values. The one exception is the deliberate reads made while busy.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFLD = 7;
  localparam int RW   = 16;

  typedef logic [RW-1:0] word_t;

  // Register byte addresses
  localparam int A_CTRL   = 'h00;
  localparam int A_STAT   = 'h02;
  localparam int A_ENA    = 'h04;
  localparam int A_MASK   = 'h08;
  localparam int A_ALM0   = 'h18;
  localparam int A_PEND   = 'h2E;
  localparam int A_COMMIT = 'h3C;

  // Bit positions
  localparam int B_BUSY = 6;
  localparam int B_HIT  = 0;
  localparam int B_LP   = 3;
  localparam int B_EN   = 0;
  localparam int B_OS   = 2;
  localparam int B_PEND = 4;
  localparam int B_DOW  = 4;

  // Compared width of each calendar field, index = slot order
  function automatic int fld_width(input int idx);
    case (idx)
      0: return 6;
      1: return 6;
      2: return 5;
      3: return 5;
      4: return 3;
      5: return 4;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/alarm_commit_ctl.sv
module alarm_commit_ctl #(
  parameter int COMMIT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic apply
);
  localparam int CW = $clog2(COMMIT_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == '0) begin
      if (start) cnt <= CW'(COMMIT_CYC);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy  = (cnt != '0);
  assign apply = (cnt == CW'(1));
endmodule

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import cal_alarm_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  word_t                    wr_data,
  input  logic                     apply,
  input  logic                     os_fire,
  output logic [NFLD-1:0][RW-1:0]  act_fld,
  output logic [NFLD-1:0]          act_mask,
  output logic                     act_en,
  output logic                     act_os
);
  localparam logic [NFLD-1:0] MASK_RST = NFLD'(1 << B_DOW);

  logic [NFLD-1:0][RW-1:0] sh_fld;
  logic [NFLD-1:0]         sh_mask;
  logic                    sh_en;
  logic                    sh_os;
  logic [NFLD-1:0]         fsel;
  logic                    mask_sel;
  logic                    ena_sel;

  genvar gi;
  generate
    for (gi = 0; gi < NFLD; gi++) begin : g_sel
      assign fsel[gi] = wr_en && (wr_addr == AW'(A_ALM0 + 2 * gi));
    end
  endgenerate

  assign mask_sel = wr_en && (wr_addr == AW'(A_MASK));
  assign ena_sel  = wr_en && (wr_addr == AW'(A_ENA));

  // Alarm field slots: shadow, then active on commit
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_fld  <= '0;
      act_fld <= '0;
    end else begin
      for (int i = 0; i < NFLD; i++) begin
        if (fsel[i]) sh_fld[i] <= wr_data;
        if (apply)   act_fld[i] <= sh_fld[i];
      end
    end
  end

  // Ignore mask and enable bits
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_mask  <= MASK_RST;
      act_mask <= MASK_RST;
      sh_en    <= 1'b0;
      sh_os    <= 1'b0;
      act_en   <= 1'b0;
      act_os   <= 1'b0;
    end else begin
      if (mask_sel) sh_mask <= wr_data[NFLD-1:0];
      if (ena_sel) begin
        sh_en <= wr_data[B_EN];
        sh_os <= wr_data[B_OS];
      end
      if (apply) begin
        act_mask <= sh_mask;
        act_en   <= sh_en;
        act_os   <= sh_os;
      end
      // one-shot disarm wins over any same-cycle update
      if (os_fire) begin
        act_en <= 1'b0;
        sh_en  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
(
  input  logic [NFLD-1:0][RW-1:0] live,
  input  logic [NFLD-1:0][RW-1:0] alm,
  input  logic [NFLD-1:0]         ign,
  output logic                    match
);
  logic [NFLD-1:0] eq;

  genvar gi;
  generate
    for (gi = 0; gi < NFLD; gi++) begin : g_cmp
      localparam int    FW = fld_width(gi);
      localparam word_t WM = word_t'((1 << FW) - 1);
      assign eq[gi] = ign[gi] | (((live[gi] ^ alm[gi]) & WM) == '0);
    end
  endgenerate

  assign match = &eq;
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int AW          = 8,
  parameter int COMMIT_CYC  = 4,
  parameter bit CLR_ON_READ = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          sec_tick,
  input  logic          lp_evt,
  input  logic [5:0]    cur_sec,
  input  logic [5:0]    cur_min,
  input  logic [4:0]    cur_hour,
  input  logic [4:0]    cur_dom,
  input  logic [2:0]    cur_dow,
  input  logic [3:0]    cur_mon,
  input  logic [6:0]    cur_year,
  output logic          alarm_irq
);
  logic [NFLD-1:0][RW-1:0] live;
  logic [NFLD-1:0][RW-1:0] act_fld;
  logic [NFLD-1:0]         act_mask;
  logic                    act_en;
  logic                    act_os;
  logic                    commit_busy;
  logic                    commit_apply;
  logic                    commit_req;
  logic                    fld_match;
  logic                    hit_now;
  logic                    os_fire;
  logic                    stat_hit;
  logic                    stat_lp;
  logic                    pend_q;
  logic                    clr_hit;
  logic                    clr_lp;
  logic                    pend_clr;
  word_t                   rd_mux;

  assign live = {RW'(cur_year), RW'(cur_mon), RW'(cur_dow), RW'(cur_dom),
                 RW'(cur_hour), RW'(cur_min), RW'(cur_sec)};

  assign commit_req = reg_we && (reg_addr == AW'(A_COMMIT)) && reg_wdata[0];

  alarm_commit_ctl #(.COMMIT_CYC(COMMIT_CYC)) u_commit (
    .clk   (clk),
    .rst   (rst),
    .start (commit_req),
    .busy  (commit_busy),
    .apply (commit_apply)
  );

  alarm_regfile #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_we),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .apply    (commit_apply),
    .os_fire  (os_fire),
    .act_fld  (act_fld),
    .act_mask (act_mask),
    .act_en   (act_en),
    .act_os   (act_os)
  );

  alarm_match u_match (
    .live  (live),
    .alm   (act_fld),
    .ign   (act_mask),
    .match (fld_match)
  );

  assign hit_now = sec_tick && act_en && fld_match;
  assign os_fire = hit_now && act_os;

  // Status clear policy picked by parameter
  generate
    if (CLR_ON_READ) begin : g_rc
      logic stat_rd;
      logic unused_wclr;
      assign stat_rd     = reg_re && (reg_addr == AW'(A_STAT));
      assign clr_hit     = stat_rd;
      assign clr_lp      = stat_rd;
      assign unused_wclr = reg_wdata[B_LP];
    end else begin : g_w1c
      logic stat_wr;
      assign stat_wr = reg_we && (reg_addr == AW'(A_STAT));
      assign clr_hit = stat_wr && reg_wdata[B_HIT];
      assign clr_lp  = stat_wr && reg_wdata[B_LP];
    end
  endgenerate

  assign pend_clr = reg_we && (reg_addr == AW'(A_PEND)) && reg_wdata[B_PEND];

  // Status and pending flags; a new event wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_hit <= 1'b0;
      stat_lp  <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (hit_now)      stat_hit <= 1'b1;
      else if (clr_hit) stat_hit <= 1'b0;
      if (lp_evt)       stat_lp  <= 1'b1;
      else if (clr_lp)  stat_lp  <= 1'b0;
      if (hit_now)       pend_q  <= 1'b1;
      else if (pend_clr) pend_q  <= 1'b0;
    end
  end

  assign alarm_irq = stat_hit;

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(A_CTRL))  rd_mux[B_BUSY] = commit_busy;
    if (reg_addr == AW'(A_STAT)) begin
      rd_mux[B_HIT] = stat_hit;
      rd_mux[B_LP]  = stat_lp;
    end
    if (reg_addr == AW'(A_ENA)) begin
      rd_mux[B_EN] = act_en;
      rd_mux[B_OS] = act_os;
    end
    if (reg_addr == AW'(A_MASK))  rd_mux[NFLD-1:0] = act_mask;
    if (reg_addr == AW'(A_PEND))  rd_mux[B_PEND] = pend_q;
    for (int i = 0; i < NFLD; i++) begin
      if (reg_addr == AW'(A_ALM0 + 2 * i)) rd_mux = act_fld[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_alarm_pkg::*;
#(
  parameter int AW          = 8,
  parameter int COMMIT_CYC  = 4,
  parameter bit CLR_ON_READ = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_we,
  input logic            reg_re,
  input logic [AW-1:0]   reg_addr,
  input logic [15:0]     reg_wdata,
  input logic            sec_tick,
  input logic            alarm_irq,
  input logic            busy,
  input logic            act_en,
  input logic            act_os,
  input logic [NFLD-1:0] act_mask,
  input logic            pend
);
  int   busy_run;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  // R3
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_irq) |-> $past(sec_tick));

  // R7
  irq_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_irq) |-> $past(act_en));

  // R6
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(alarm_irq) && $past(act_os)) |-> !act_en);

  // R2
  mask_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_mask) |-> ($past(busy) && !busy));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_we && (reg_addr == AW'(A_COMMIT)) && reg_wdata[0]));

  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy_run <= COMMIT_CYC);

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> $past(reg_we && (reg_addr == AW'(A_PEND)) && reg_wdata[B_PEND]));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_irq) |->
      ((CLR_ON_READ && $past(reg_re && (reg_addr == AW'(A_STAT)))) ||
       (!CLR_ON_READ && $past(reg_we && (reg_addr == AW'(A_STAT)) && reg_wdata[B_HIT]))));
endmodule

bind cal_alarm_unit cal_alarm_chk #(
  .AW          (AW),
  .COMMIT_CYC  (COMMIT_CYC),
  .CLR_ON_READ (CLR_ON_READ)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sec_tick  (sec_tick),
  .alarm_irq (alarm_irq),
  .busy      (commit_busy),
  .act_en    (act_en),
  .act_os    (act_os),
  .act_mask  (act_mask),
  .pend      (pend_q)
);

// File: tb/sim_cal_alarm_unit.sv
`timescale 1ns/1ps
module sim_cal_alarm_unit;
  localparam int CC = 4;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h02, A_ENA = 8'h04,
                         A_MASK = 8'h08, A_ALM0 = 8'h18, A_PEND = 8'h2E,
                         A_COMMIT = 8'h3C;
  // {mask7, year7, mon4, dow3, dom5, hour5, min6, sec6, expect}
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {7'h10, 7'd55, 4'd6, 3'd5, 5'd12, 5'd10, 6'd15, 6'd30, 1'b1},
    {7'h10, 7'd55, 4'd6, 3'd3, 5'd12, 5'd10, 6'd15, 6'd31, 1'b0},
    {7'h00, 7'd55, 4'd6, 3'd5, 5'd12, 5'd10, 6'd15, 6'd30, 1'b0},
    {7'h00, 7'd55, 4'd6, 3'd3, 5'd12, 5'd10, 6'd15, 6'd30, 1'b1},
    {7'h01, 7'd55, 4'd6, 3'd3, 5'd12, 5'd10, 6'd15, 6'd0,  1'b1},
    {7'h7F, 7'd1,  4'd1, 3'd0, 5'd1,  5'd1,  6'd1,  6'd1,  1'b1},
    {7'h10, 7'd54, 4'd6, 3'd3, 5'd12, 5'd10, 6'd15, 6'd30, 1'b0},
    {7'h60, 7'd0,  4'd1, 3'd3, 5'd12, 5'd10, 6'd15, 6'd30, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sec_tick = 1'b0, lp_evt = 1'b0;
  logic [5:0]  cur_sec = '0, cur_min = '0;
  logic [4:0]  cur_hour = '0, cur_dom = '0;
  logic [2:0]  cur_dow = '0;
  logic [3:0]  cur_mon = '0;
  logic [6:0]  cur_year = '0;
  logic        alarm_irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cal_alarm_unit u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick), .lp_evt(lp_evt),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_dom(cur_dom),
    .cur_dow(cur_dow), .cur_mon(cur_mon), .cur_year(cur_year), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic commit();
    wr(A_COMMIT, 16'h0001);
    idle(CC);
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic live_alarm();
    cur_sec = 6'd30; cur_min = 6'd15; cur_hour = 5'd10; cur_dom = 5'd12;
    cur_dow = 3'd3; cur_mon = 4'd6; cur_year = 7'd55;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [43:0] v;
    idle(4);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'd0, alarm_irq}, 16'h0000);
    rd(A_MASK, d); check("R1 mask", d, 16'h0010);
    rd(A_ENA, d);  check("R1 ena", d, 16'h0000);
    rd(A_STAT, d); check("R1 stat", d, 16'h0000);
    rd(A_PEND, d); check("R1 pend", d, 16'h0000);
    rd(A_CTRL, d); check("R1 ctrl", d, 16'h0000);
    rd(A_ALM0, d); check("R1 slot", d, 16'h0000);

    // program alarm: 30 s, 15 min, 10 h, day 12, dow 3, month 6, year 55
    wr(A_ALM0 + 0, 16'd30); wr(A_ALM0 + 2, 16'd15); wr(A_ALM0 + 4, 16'd10);
    wr(A_ALM0 + 6, 16'd12); wr(A_ALM0 + 8, 16'd3);  wr(A_ALM0 + 10, 16'd6);
    wr(A_ALM0 + 12, 16'd55); wr(A_ENA, 16'h0001);
    commit();

    // R3 / R4 vector walk
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      wr(A_MASK, {9'd0, v[43:37]});
      commit();
      cur_year = v[36:30]; cur_mon = v[29:26]; cur_dow = v[25:23]; cur_dom = v[22:18];
      cur_hour = v[17:13]; cur_min = v[12:7]; cur_sec = v[6:1];
      tick();
      check($sformatf("R3/R4 vector %0d", k), {15'd0, alarm_irq}, {15'd0, v[0]});
      wr(A_STAT, 16'h0001);
      wr(A_PEND, 16'h0010);
    end
    wr(A_MASK, 16'h0010);
    commit();
    live_alarm();

    // R3 no tick, no match
    idle(5);
    check("R3 no tick", {15'd0, alarm_irq}, 16'h0000);

    // R8 / R9 pending and status clear
    tick();
    check("R3 match irq", {15'd0, alarm_irq}, 16'h0001);
    rd(A_PEND, d); check("R8 pend set", d, 16'h0010);
    wr(A_STAT, 16'h0000);
    check("R9 write 0 keeps", {15'd0, alarm_irq}, 16'h0001);
    wr(A_STAT, 16'h0001);
    check("R9 w1c irq", {15'd0, alarm_irq}, 16'h0000);
    rd(A_STAT, d); check("R9 stat cleared", d, 16'h0000);
    rd(A_PEND, d); check("R8 pend kept", d, 16'h0010);
    wr(A_PEND, 16'h0010);
    rd(A_PEND, d); check("R8 pend cleared", d, 16'h0000);

    // R2 shadow then commit
    wr(A_ALM0, 16'd45);
    wr(A_COMMIT, 16'h0001);
    rd(A_ALM0, d); check("R2 old while busy", d, 16'd30);
    rd(A_CTRL, d); check("R2 busy bit", d, 16'h0040);
    idle(2);
    rd(A_ALM0, d); check("R2 new after commit", d, 16'd45);
    rd(A_CTRL, d); check("R2 busy dropped", d, 16'h0000);

    // R11 second commit while busy ignored
    wr(A_COMMIT, 16'h0001);
    wr(A_COMMIT, 16'h0001);
    idle(CC - 1);
    rd(A_CTRL, d); check("R11 busy not extended", d, 16'h0000);

    // R5 upper bits stored, ignored by compare
    wr(A_ALM0, 16'hAB1E);
    commit();
    rd(A_ALM0, d); check("R5 readback", d, 16'hAB1E);
    tick();
    check("R5 low bits match", {15'd0, alarm_irq}, 16'h0001);
    wr(A_STAT, 16'h0001);
    wr(A_PEND, 16'h0010);

    // R6 one-shot
    wr(A_ENA, 16'h0005);
    commit();
    tick();
    check("R6 fires", {15'd0, alarm_irq}, 16'h0001);
    rd(A_ENA, d); check("R6 disarmed", d, 16'h0004);
    wr(A_STAT, 16'h0001);
    wr(A_PEND, 16'h0010);
    tick();
    check("R6 no second fire", {15'd0, alarm_irq}, 16'h0000);

    // R7 disabled alarm
    wr(A_ENA, 16'h0000);
    commit();
    tick();
    check("R7 irq off", {15'd0, alarm_irq}, 16'h0000);
    rd(A_STAT, d); check("R7 stat", d, 16'h0000);
    rd(A_PEND, d); check("R7 pend", d, 16'h0000);

    // R10 low-power status
    lp_evt = 1'b1;
    @(negedge clk);
    lp_evt = 1'b0;
    check("R10 no irq", {15'd0, alarm_irq}, 16'h0000);
    rd(A_STAT, d); check("R10 lp set", d, 16'h0008);
    wr(A_STAT, 16'h0008);
    rd(A_STAT, d); check("R10 lp cleared", d, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule